// File: doc/BRIEF.md
# Key-Sequence Register Write Unlock

This block protects a group of configuration registers from stray writes. Software unlocks them by writing a fixed series of bytes, in order, to one 8-bit key register on a simple register bus. The bus has an address, write data and a single-cycle write strobe. When the last byte of the series arrives, an unlock flag is set. From then on the block passes protected writes through its write-enable qualifier output. A dedicated relock byte written to the key register clears the flag again.

The qualifier `prot_we_o` is meant to gate the write enables of the protected registers, which sit outside this block. Software can read the unlock flag back on bit 0 of the key register address.

Top module: `key_unlock_guard`

## Requirements
- R1: `unlocked_o` goes from 0 to 1 only after the key register (address `KEY_ADDR`, default 0x00) is written with 0x32, 0x5D, 0x42 and then 0xAC, in that order.
- R2: `prot_we_o` is 1 exactly when `we_i` is 1, `addr_i` is not `KEY_ADDR` and the block is unlocked. While the block is locked, no protected write is qualified.
- R3: While the block is unlocked, writing 0x35 to the key register clears `unlocked_o` on the next clock edge.
- R4: After reset, the block is locked and the sequence matcher is idle.
- R5: While the block is locked, a key byte that does not match the next expected byte sends the matcher back to idle. If that byte is 0x32, it counts as the first byte of a new attempt.
- R6: While the block is unlocked, writing any byte other than 0x35 to the key register leaves `unlocked_o` at 1.
- R7: Writes to any address other than `KEY_ADDR` neither advance nor reset the sequence matcher.
- R8: When `addr_i` equals `KEY_ADDR`, `rdata_o` is the unlock flag in bit 0 with bits 7..1 at 0. For any other address, `rdata_o` is 0.
- R9: The unlock takes effect on the clock edge that captures the final sequence byte. A protected write in the very next cycle is therefore qualified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data byte |
| we_i | input | 1 | Single-cycle write strobe |
| rdata_o | output | 8 | Read data for the key register address |
| unlocked_o | output | 1 | Unlock flag |
| prot_we_o | output | 1 | Write-enable qualifier for protected registers |

## Verification
The assertions take for granted that `addr_i`, `wdata_i` and `we_i` hold known values at every clock edge after reset. They also assume that one strobe stands for exactly one write. The bench changes its inputs only on the falling edge and always drives all three to defined values, so no strobe spans an unclear edge. The random bytes are biased toward the sequence bytes and the relock byte, so that partial matches, restarts and relocks all occur, while `we_i` and `addr_i` stay within their legal encodings.

// File: rtl/key_unlock_pkg.sv
package key_unlock_pkg;
  typedef logic [7:0] byte_t;
  localparam int unsigned DEF_SEQ_LEN = 4;
  localparam logic [DEF_SEQ_LEN-1:0][7:0] DEF_KEY_SEQ = {8'hAC, 8'h42, 8'h5D, 8'h32};
  localparam byte_t DEF_RELOCK = 8'h35;
endpackage

// File: rtl/key_seq_matcher.sv
module key_seq_matcher
  import key_unlock_pkg::*;
#(
  parameter int unsigned SEQ_LEN = DEF_SEQ_LEN,
  parameter logic [SEQ_LEN-1:0][7:0] KEY_SEQ = DEF_KEY_SEQ,
  localparam int unsigned CNT_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_wr_i,
  input  byte_t            wdata_i,
  input  logic             unlocked_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SEQ_LEN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_o = 1'b0;
    if (unlocked_i) begin
      cnt_d = '0;
    end else if (key_wr_i) begin
      if (wdata_i == KEY_SEQ[cnt_q]) begin
        if (cnt_q == LAST) begin
          done_o = 1'b1;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (wdata_i == KEY_SEQ[0]) begin
        cnt_d = CNT_W'(1);  // restart: byte opens a new attempt
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/key_lock_flag.sv
module key_lock_flag
  import key_unlock_pkg::*;
#(
  parameter byte_t RELOCK_BYTE = DEF_RELOCK
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  key_wr_i,
  input  byte_t wdata_i,
  input  logic  set_i,
  output logic  ok_o
);
  logic ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                       ok_q <= 1'b0;
    else if (set_i)                                    ok_q <= 1'b1;
    else if (ok_q && key_wr_i && wdata_i == RELOCK_BYTE) ok_q <= 1'b0;
  end

  assign ok_o = ok_q;
endmodule

// File: rtl/key_unlock_guard.sv
module key_unlock_guard
  import key_unlock_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = '0,
  parameter int unsigned SEQ_LEN = DEF_SEQ_LEN,
  parameter logic [SEQ_LEN-1:0][7:0] KEY_SEQ = DEF_KEY_SEQ,
  parameter byte_t RELOCK_BYTE = DEF_RELOCK,
  localparam int unsigned CNT_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              we_i,
  output logic [7:0]        rdata_o,
  output logic              unlocked_o,
  output logic              prot_we_o
);
  logic             key_sel, key_wr, seq_done, ok;
  logic [CNT_W-1:0] match_cnt;

  assign key_sel = (addr_i == KEY_ADDR);
  assign key_wr  = we_i && key_sel;

  key_seq_matcher #(.SEQ_LEN(SEQ_LEN), .KEY_SEQ(KEY_SEQ)) u_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .key_wr_i  (key_wr),
    .wdata_i   (wdata_i),
    .unlocked_i(ok),
    .cnt_o     (match_cnt),
    .done_o    (seq_done)
  );

  key_lock_flag #(.RELOCK_BYTE(RELOCK_BYTE)) u_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .key_wr_i(key_wr),
    .wdata_i (wdata_i),
    .set_i   (seq_done),
    .ok_o    (ok)
  );

  assign unlocked_o = ok;
  assign prot_we_o  = we_i && !key_sel && ok;
  assign rdata_o    = key_sel ? {7'b0, ok} : 8'h00;
endmodule

// File: rtl/key_unlock_guard_chk.sv
module key_unlock_guard_chk
  import key_unlock_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = '0,
  parameter int unsigned SEQ_LEN = DEF_SEQ_LEN,
  parameter logic [SEQ_LEN-1:0][7:0] KEY_SEQ = DEF_KEY_SEQ,
  parameter byte_t RELOCK_BYTE = DEF_RELOCK,
  parameter int unsigned CNT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic              we_i,
  input logic              unlocked_o,
  input logic              prot_we_o,
  input logic [CNT_W-1:0]  match_cnt
);
  logic kw;
  assign kw = we_i && (addr_i == KEY_ADDR);

  a_r1_unlock_on_last_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_o) |-> $past(kw && wdata_i == KEY_SEQ[SEQ_LEN-1]));

  a_r2_qualify_needs_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_we_o |-> (unlocked_o && we_i));

  a_r3_relock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked_o && kw && wdata_i == RELOCK_BYTE) |=> !unlocked_o);

  a_r3_fall_only_on_relock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(unlocked_o) |-> $past(kw && wdata_i == RELOCK_BYTE));

  a_r6_hold_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked_o && kw && wdata_i != RELOCK_BYTE) |=> unlocked_o);

  a_r7_other_addr_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!kw && !unlocked_o) |=> $stable(match_cnt));
endmodule

bind key_unlock_guard key_unlock_guard_chk #(
  .ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR), .SEQ_LEN(SEQ_LEN),
  .KEY_SEQ(KEY_SEQ), .RELOCK_BYTE(RELOCK_BYTE), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
  .we_i(we_i), .unlocked_o(unlocked_o), .prot_we_o(prot_we_o),
  .match_cnt(match_cnt)
);

// File: tb/key_unlock_guard_test.sv
`timescale 1ns/1ps
module key_unlock_guard_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr_i = 8'h00, wdata_i = 8'h00, rdata_o;
  logic       we_i = 1'b0, unlocked_o, prot_we_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic       m_ok = 1'b0;
  int         m_cnt = 0;
  logic [7:0] seq [4] = '{8'h32, 8'h5D, 8'h42, 8'hAC};

  always #2.5 clk_i = ~clk_i;

  key_unlock_guard uut (.*);

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model step, from the requirements
  function automatic void model_step(input logic we, input logic [7:0] a, input logic [7:0] d);
    if (!(we && a == 8'h00)) return;  // R7
    if (m_ok) begin
      if (d == 8'h35) m_ok = 1'b0;    // R3, R6
    end else if (d == seq[m_cnt]) begin
      if (m_cnt == 3) begin m_ok = 1'b1; m_cnt = 0; end
      else m_cnt++;
    end else m_cnt = (d == 8'h32) ? 1 : 0;  // R5
  endfunction

  // one bus cycle: drive on negedge, check combinational outputs, then clock
  task automatic cyc(input logic we, input logic [7:0] a, input logic [7:0] d, input string tag);
    @(negedge clk_i);
    we_i = we; addr_i = a; wdata_i = d;
    #1;
    chk(unlocked_o == m_ok, {tag, " R1 unlocked"}, unlocked_o, m_ok);
    chk(prot_we_o == (we && a != 8'h00 && m_ok), {tag, " R2 prot_we"}, prot_we_o,
        we && a != 8'h00 && m_ok);
    chk(rdata_o == ((a == 8'h00) ? {7'b0, m_ok} : 8'h00), {tag, " R8 rdata"}, rdata_o,
        (a == 8'h00) ? {7'b0, m_ok} : 8'h00);
    @(posedge clk_i);
    model_step(we, a, d);
  endtask

  task automatic key(input logic [7:0] d, input string tag);
    cyc(1'b1, 8'h00, d, tag);
  endtask

  task automatic unlock(input string tag);
    for (int i = 0; i < 4; i++) key(seq[i], tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'd1862;
    void'($urandom(seed));
    #12;
    chk(unlocked_o == 1'b0, "R4 reset locked", unlocked_o, 0);
    chk(prot_we_o == 1'b0, "R4 reset no qualify", prot_we_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R4: partial sequence after reset must need all four bytes
    cyc(1'b1, 8'h10, 8'hAA, "R4 locked write");
    unlock("R1 full seq");
    cyc(1'b1, 8'h20, 8'h55, "R9 next-cycle write");  // R9
    key(8'h32, "R6 other byte");
    key(8'hAC, "R6 other byte");
    cyc(1'b0, 8'h00, 8'h00, "R6 hold");
    key(8'h35, "R3 relock");
    cyc(1'b1, 8'h30, 8'h01, "R3 after relock");
    // R5 restart on 0x32, mismatch
    key(8'h32, "R5"); key(8'h5D, "R5"); key(8'h32, "R5 restart");
    key(8'h5D, "R5"); key(8'h42, "R5"); key(8'hAC, "R5 complete");
    key(8'h35, "R3 relock");
    key(8'h32, "R5"); key(8'h00, "R5 mismatch"); key(8'h5D, "R5");
    key(8'h42, "R5"); key(8'hAC, "R5 no unlock");
    key(8'h35, "R5 relock while locked");
    // R7 other-address writes mid sequence
    key(8'h32, "R7"); cyc(1'b1, 8'h44, 8'h00, "R7 other addr");
    key(8'h5D, "R7"); cyc(1'b1, 8'h01, 8'h32, "R7 other addr");
    key(8'h42, "R7"); key(8'hAC, "R7 unlock");
    key(8'h35, "R3 relock");
    // R5 reversed order never unlocks
    for (int i = 3; i >= 0; i--) key(seq[i], "R5 reversed");

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d, a;
      logic we;
      case ($urandom_range(0, 5))
        0, 1: d = seq[$urandom_range(0, 3)];
        2:    d = seq[m_cnt];
        3:    d = 8'h35;
        default: d = 8'($urandom);
      endcase
      a  = ($urandom_range(0, 3) != 0) ? 8'h00 : 8'($urandom_range(1, 255));
      we = ($urandom_range(0, 7) != 0);
      cyc(we, a, d, "R1 R5 R6 R7 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule